// File: doc/BRIEF.md
# Clock Source and Standby Controller

This block decides which oscillator drives a small processor core and when that core's clock is stopped. It has an enable for a slow and a fast oscillator and a select that moves the core clock between them. It also runs a mode machine with three states: running, a light standby in which the oscillators keep their state, and a deep standby in which both oscillators are stopped.

Software reaches it through a configuration write that carries both the fast-oscillator enable and the clock select. The core raises one-cycle requests to enter either standby state. Interrupt lines bring the core back. Two programmable settle counts model the time the fast oscillator needs before it can be selected, and the time the slow oscillator needs before the core clock comes back after deep standby.

Top module: `clk_standby_ctrl`

## Requirements
- R1: After reset the slow oscillator is on, the fast oscillator is off, the select is 0, the core clock is running, and both standby states and both error bits read 0.
- R2: In run mode, a write sets `osc_hs_en` from `cfg_hs_en`, unless R4 applies. `hs_ready` reads 1 once `osc_hs_en` has been 1 for `stab_hs_cycles` clock edges, and reads 0 whenever the fast oscillator is off.
- R3: A write of `cfg_sel_hs`=1 sets `clk_sel_hs` only when `hs_ready` is already 1 and the same write keeps `cfg_hs_en`=1. Otherwise the select keeps its previous value.
- R4: While `clk_sel_hs` is 1, a write with `cfg_hs_en`=0 leaves the fast oscillator on and applies only the select field. It also sets the sticky bit `err_sel_clr`.
- R5: A `halt_req` in run mode stops `cpu_clk_en` and raises `st_halt` on the next edge. Both oscillator enables and the select keep their values, and configuration writes have no effect in any standby state.
- R6: While halted, a pulse on `irq_req`, `nmi_req` or `key_wake` returns to run mode at the next edge.
- R7: A `sleep_req` in run mode with the select at 0 drops `cpu_clk_en`, `osc_ls_en` and `osc_hs_en` and raises `st_sleep` at the next edge.
- R8: In deep standby, `irq_req` and `nmi_req` are ignored. A `key_wake` turns the slow oscillator on at the next edge. The core clock returns after a further `stab_ls_cycles`+1 edges, and `st_sleep` stays 1 until then.
- R9: A `sleep_req` while `clk_sel_hs` is 1 is refused: the block stays in run mode and sets the sticky bit `err_sleep_hs`.
- R10: On return from deep standby, `osc_hs_en` takes back the value it held when deep standby was entered. Its settle count starts again from zero.
- R11: In a cycle where `sleep_req` or `halt_req` is high, a configuration write is dropped. When both requests are high, only the deep-standby request is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stab_hs_cycles | input | CNT_W | Settle count for the fast oscillator |
| stab_ls_cycles | input | CNT_W | Settle count for the slow oscillator after deep standby |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_hs_en | input | 1 | Written fast-oscillator enable |
| cfg_sel_hs | input | 1 | Written clock select (1 = fast) |
| halt_req | input | 1 | Light standby request |
| sleep_req | input | 1 | Deep standby request |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| key_wake | input | 1 | Key-input interrupt request |
| osc_ls_en | output | 1 | Slow oscillator enable |
| osc_hs_en | output | 1 | Fast oscillator enable |
| clk_sel_hs | output | 1 | Core clock source select |
| cpu_clk_en | output | 1 | Core clock gate enable |
| hs_ready | output | 1 | Fast oscillator settled |
| st_halt | output | 1 | Light standby active |
| st_sleep | output | 1 | Deep standby or its wake settle active |
| err_sel_clr | output | 1 | Sticky: disallowed fast-oscillator disable |
| err_sleep_hs | output | 1 | Sticky: deep standby refused on fast clock |

## Verification
The assertions assume that both settle counts are held constant from reset onward, because a count changed while a settle window is open would move the point at which `hs_ready` or the wake exit fires. They also assume that every control input is a known level sampled at the rising edge. The stimulus loads the counts only while reset is asserted and changes every other input at the falling edge. Request pulses arrive in any combination, including writes that collide with standby requests and interrupts that arrive during deep standby.

// File: rtl/clk_standby_pkg.sv
package clk_standby_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } cs_state_e;

    typedef struct packed {
        cs_state_e state;
        logic      hs_en;
        logic      sel;
        logic      saved_hs;
        logic      err_pair;
        logic      err_sleep;
    } cs_regs_t;

endpackage

// File: rtl/cs_settle_cnt.sv
module cs_settle_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q < limit) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
        done = run && (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cs_cfg_rules.sv
module cs_cfg_rules (
    input  logic sel_q,
    input  logic hs_ready,
    input  logic wr_sel,
    input  logic wr_hs_en,
    output logic sel_n,
    output logic hs_en_n,
    output logic err
);
    always_comb begin
        // fast oscillator may not be dropped while it feeds the core
        hs_en_n = wr_hs_en | sel_q;
        err     = sel_q & ~wr_hs_en;
        if (!wr_sel) begin
            sel_n = 1'b0;
        end else begin
            sel_n = sel_q | (hs_ready & wr_hs_en);
        end
    end
endmodule

// File: rtl/clk_standby_ctrl.sv
module clk_standby_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] stab_hs_cycles,
    input  logic [CNT_W-1:0] stab_ls_cycles,
    input  logic             cfg_wr,
    input  logic             cfg_hs_en,
    input  logic             cfg_sel_hs,
    input  logic             halt_req,
    input  logic             sleep_req,
    input  logic             irq_req,
    input  logic             nmi_req,
    input  logic             key_wake,
    output logic             osc_ls_en,
    output logic             osc_hs_en,
    output logic             clk_sel_hs,
    output logic             cpu_clk_en,
    output logic             hs_ready,
    output logic             st_halt,
    output logic             st_sleep,
    output logic             err_sel_clr,
    output logic             err_sleep_hs
);
    import clk_standby_pkg::*;

    cs_regs_t r_d, r_q;
    logic     ls_done;
    logic     rule_sel, rule_hs, rule_err;
    logic     in_wake;

    assign in_wake = (r_q.state == ST_WAKE);

    cs_settle_cnt #(.CNT_W(CNT_W)) u_hs_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.hs_en),
        .limit (stab_hs_cycles),
        .done  (hs_ready)
    );

    cs_settle_cnt #(.CNT_W(CNT_W)) u_ls_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_wake),
        .limit (stab_ls_cycles),
        .done  (ls_done)
    );

    cs_cfg_rules u_rules (
        .sel_q    (r_q.sel),
        .hs_ready (hs_ready),
        .wr_sel   (cfg_sel_hs),
        .wr_hs_en (cfg_hs_en),
        .sel_n    (rule_sel),
        .hs_en_n  (rule_hs),
        .err      (rule_err)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_RUN: begin
                if (sleep_req) begin
                    if (r_q.sel) begin
                        r_d.err_sleep = 1'b1;
                    end else begin
                        r_d.state    = ST_SLEEP;
                        r_d.saved_hs = r_q.hs_en;
                        r_d.hs_en    = 1'b0;
                    end
                end else if (halt_req) begin
                    r_d.state = ST_HALT;
                end else if (cfg_wr) begin
                    r_d.sel   = rule_sel;
                    r_d.hs_en = rule_hs;
                    if (rule_err) begin
                        r_d.err_pair = 1'b1;
                    end
                end
            end
            ST_HALT: begin
                if (irq_req || nmi_req || key_wake) begin
                    r_d.state = ST_RUN;
                end
            end
            ST_SLEEP: begin
                if (key_wake) begin
                    r_d.state = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (ls_done) begin
                    r_d.state = ST_RUN;
                    r_d.hs_en = r_q.saved_hs;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_RUN, hs_en: 1'b0, sel: 1'b0, saved_hs: 1'b0,
                     err_pair: 1'b0, err_sleep: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign osc_ls_en    = (r_q.state != ST_SLEEP);
    assign osc_hs_en    = r_q.hs_en;
    assign clk_sel_hs   = r_q.sel;
    assign cpu_clk_en   = (r_q.state == ST_RUN);
    assign st_halt      = (r_q.state == ST_HALT);
    assign st_sleep     = (r_q.state == ST_SLEEP) || (r_q.state == ST_WAKE);
    assign err_sel_clr  = r_q.err_pair;
    assign err_sleep_hs = r_q.err_sleep;
endmodule

// File: rtl/clk_standby_chk.sv
module clk_standby_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic irq_req,
    input logic nmi_req,
    input logic key_wake,
    input logic osc_ls_en,
    input logic osc_hs_en,
    input logic clk_sel_hs,
    input logic cpu_clk_en,
    input logic hs_ready,
    input logic st_halt,
    input logic st_sleep,
    input logic err_sleep_hs
);
    AST_SLEEP_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_ls_en |-> (!osc_hs_en && !cpu_clk_en && st_sleep)); // R7

    AST_SEL_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel_hs) |-> $past(hs_ready)); // R3

    AST_SEL_KEEPS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_hs |-> osc_hs_en); // R4

    AST_HALT_OSC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_halt && $past(st_halt)) |-> ($stable(osc_hs_en) && $stable(clk_sel_hs) && osc_ls_en)); // R5

    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_halt && (irq_req || nmi_req || key_wake)) |=> cpu_clk_en); // R6

    AST_SLEEP_KEY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_ls_en && !key_wake) |=> !osc_ls_en); // R8

    AST_SLEEP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && clk_sel_hs && sleep_req) |=> (cpu_clk_en && err_sleep_hs)); // R9

    AST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cpu_clk_en, st_halt, st_sleep}) == 1); // R5
endmodule

bind clk_standby_ctrl clk_standby_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .irq_req      (irq_req),
    .nmi_req      (nmi_req),
    .key_wake     (key_wake),
    .osc_ls_en    (osc_ls_en),
    .osc_hs_en    (osc_hs_en),
    .clk_sel_hs   (clk_sel_hs),
    .cpu_clk_en   (cpu_clk_en),
    .hs_ready     (hs_ready),
    .st_halt      (st_halt),
    .st_sleep     (st_sleep),
    .err_sleep_hs (err_sleep_hs)
);

// File: tb/clk_standby_ctrl_tb.sv
module clk_standby_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic [CNT_W-1:0] stab_hs_cycles, stab_ls_cycles;
    logic cfg_wr, cfg_hs_en, cfg_sel_hs, halt_req, sleep_req, irq_req, nmi_req, key_wake;
    logic osc_ls_en, osc_hs_en, clk_sel_hs, cpu_clk_en, hs_ready;
    logic st_halt, st_sleep, err_sel_clr, err_sleep_hs;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model: 0 run, 1 halt, 2 sleep, 3 wake-settle
    int m_state, m_hc, m_lc;
    logic m_hs, m_sel, m_saved, m_ep, m_es;

    always #(CLK_P/2) clk = ~clk;

    clk_standby_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .stab_hs_cycles(stab_hs_cycles), .stab_ls_cycles(stab_ls_cycles),
        .cfg_wr(cfg_wr), .cfg_hs_en(cfg_hs_en), .cfg_sel_hs(cfg_sel_hs),
        .halt_req(halt_req), .sleep_req(sleep_req), .irq_req(irq_req),
        .nmi_req(nmi_req), .key_wake(key_wake),
        .osc_ls_en(osc_ls_en), .osc_hs_en(osc_hs_en), .clk_sel_hs(clk_sel_hs),
        .cpu_clk_en(cpu_clk_en), .hs_ready(hs_ready), .st_halt(st_halt),
        .st_sleep(st_sleep), .err_sel_clr(err_sel_clr), .err_sleep_hs(err_sleep_hs)
    );

    function automatic logic exp_ready();
        return m_hs && (m_hc >= int'(stab_hs_cycles));
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_all();
        chk("R7", "osc_ls_en", osc_ls_en, m_state != 2);
        chk("R2", "osc_hs_en", osc_hs_en, m_hs);
        chk("R3", "clk_sel_hs", clk_sel_hs, m_sel);
        chk("R5", "cpu_clk_en", cpu_clk_en, m_state == 0);
        chk("R2", "hs_ready", hs_ready, exp_ready());
        chk("R6", "st_halt", st_halt, m_state == 1);
        chk("R8", "st_sleep", st_sleep, m_state >= 2);
        chk("R4", "err_sel_clr", err_sel_clr, m_ep);
        chk("R9", "err_sleep_hs", err_sleep_hs, m_es);
    endtask

    // advance the model by one edge, from the requirements
    task automatic model_edge();
        logic rdy, ldone, nhs;
        int   ns, nhc, nlc;
        rdy   = exp_ready();
        ldone = (m_state == 3) && (m_lc >= int'(stab_ls_cycles));
        nhc   = m_hs ? ((m_hc < int'(stab_hs_cycles)) ? m_hc + 1 : m_hc) : 0;
        nlc   = (m_state == 3) ? ((m_lc < int'(stab_ls_cycles)) ? m_lc + 1 : m_lc) : 0;
        ns    = m_state;
        nhs   = m_hs;
        if (m_state == 0) begin
            if (sleep_req) begin
                if (m_sel) m_es = 1'b1;
                else begin ns = 2; m_saved = m_hs; nhs = 1'b0; end
            end else if (halt_req) begin
                ns = 1;
            end else if (cfg_wr) begin
                if (m_sel && !cfg_hs_en) begin
                    nhs = 1'b1; m_ep = 1'b1;
                    m_sel = cfg_sel_hs;
                end else begin
                    nhs = cfg_hs_en;
                    if (!cfg_sel_hs) m_sel = 1'b0;
                    else if (!m_sel) m_sel = rdy && cfg_hs_en;
                end
            end
        end else if (m_state == 1) begin
            if (irq_req || nmi_req || key_wake) ns = 0;
        end else if (m_state == 2) begin
            if (key_wake) ns = 3;
        end else begin
            if (ldone) begin ns = 0; nhs = m_saved; end
        end
        m_state = ns; m_hs = nhs; m_hc = nhc; m_lc = nlc;
    endtask

    task automatic step(input logic wr, input logic he, input logic se, input logic h,
                        input logic s, input logic i, input logic n, input logic k);
        @(negedge clk);
        cfg_wr = wr; cfg_hs_en = he; cfg_sel_hs = se;
        halt_req = h; sleep_req = s; irq_req = i; nmi_req = n; key_wake = k;
        @(posedge clk);
        model_edge();
        #1;
        chk_all();
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset(input int hs_lim, input int ls_lim);
        @(negedge clk);
        rst_n = 1'b0;
        stab_hs_cycles = CNT_W'(hs_lim);
        stab_ls_cycles = CNT_W'(ls_lim);
        cfg_wr = 0; cfg_hs_en = 0; cfg_sel_hs = 0; halt_req = 0;
        sleep_req = 0; irq_req = 0; nmi_req = 0; key_wake = 0;
        m_state = 0; m_hc = 0; m_lc = 0;
        m_hs = 0; m_sel = 0; m_saved = 0; m_ep = 0; m_es = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset osc_ls_en", osc_ls_en, 1'b1);
        chk("R1", "reset osc_hs_en", osc_hs_en, 1'b0);
        chk("R1", "reset clk_sel_hs", clk_sel_hs, 1'b0);
        chk("R1", "reset cpu_clk_en", cpu_clk_en, 1'b1);
        chk("R1", "reset status", st_halt | st_sleep | err_sel_clr | err_sleep_hs, 1'b0);
    endtask

    task automatic random_run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            logic w, h, s, i, n, k;
            w = ($urandom % 100) < 20;
            h = ($urandom % 100) < 5;
            s = ($urandom % 100) < 5;
            i = ($urandom % 100) < 6;
            n = ($urandom % 100) < 3;
            k = ($urandom % 100) < 5;
            step(w, ($urandom % 100) < 70, $urandom % 2, h, s, i, n, k);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset(6, 3);

        step(1, 1, 1, 0, 0, 0, 0, 0);                 // enable fast, select too early
        chk("R3", "select refused before settle", clk_sel_hs, 1'b0);
        idle(7);
        chk("R2", "hs_ready after settle", hs_ready, 1'b1);
        step(1, 1, 1, 0, 0, 0, 0, 0);
        chk("R3", "select accepted when ready", clk_sel_hs, 1'b1);

        step(1, 0, 0, 0, 1, 0, 0, 0);                 // sleep on fast clock with a write
        chk("R9", "sleep refused on fast clock", err_sleep_hs, 1'b1);
        chk("R11", "write dropped with request", clk_sel_hs, 1'b1);

        step(1, 0, 0, 0, 0, 0, 0, 0);                 // clear both in one write
        chk("R4", "fast osc kept on", osc_hs_en, 1'b1);
        chk("R4", "select cleared", clk_sel_hs, 1'b0);
        chk("R4", "pair error set", err_sel_clr, 1'b1);

        step(0, 0, 0, 0, 1, 0, 0, 0);                 // deep standby with fast osc on
        chk("R7", "slow osc off in sleep", osc_ls_en, 1'b0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        step(1, 1, 1, 0, 0, 0, 1, 0);
        chk("R8", "irq/nmi ignored in sleep", st_sleep & ~osc_ls_en, 1'b1);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R8", "slow osc on after key", osc_ls_en, 1'b1);
        idle(3);
        chk("R8", "core still gated during settle", cpu_clk_en, 1'b0);
        idle(1);
        chk("R8", "core released after settle", cpu_clk_en, 1'b1);
        chk("R10", "fast osc restored", osc_hs_en, 1'b1);
        chk("R10", "fast settle restarted", hs_ready, 1'b0);

        step(0, 0, 0, 1, 1, 0, 0, 0);                 // both requests
        chk("R11", "sleep wins over halt", st_sleep & ~st_halt, 1'b1);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(5);

        step(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R5", "halt gates core", cpu_clk_en, 1'b0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R5", "write ignored in halt", osc_hs_en, 1'b1);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R6", "nmi ends halt", cpu_clk_en, 1'b1);

        random_run(4000);

        do_reset(0, 1);
        random_run(4000);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule